// File: doc/BRIEF.md
# Run-Time Sized PCI Memory Base Address Register

This block is one 32-bit memory Base Address Register of a PCI target. The size of its decode window is not fixed when the chip is built. A 4-bit size code chooses the size while the chip runs: one value turns the register off, twelve values give naturally aligned windows from 2 GB down to 1 MB, and three values give small windows of 64 KB, 32 KB or 16 KB. The small windows also raise a flag that tells later logic to translate addresses through an internal window.

Configuration software writes the register through a write strobe and a data word, and reads it back through a combinational read port. The read shows only the base bits that the current size allows, so software can size the window in the usual way: write all ones, then read back. Every bus address is compared against the stored base. The block gives a hit, and the offset of the address inside the window, in the same cycle as the address. By default a base of zero never decodes. A separate control input allows a zero base to decode like any other value.

Top module: `pci_sized_bar`

## Requirements
- R1: With size code 0 the register is off: `hit`, `win_en` and `offset` are all 0, and `cfg_rd_data` reads 0, whatever was written before.
- R2: Size codes 1 to 12 (0x1 to 0xC) select a window of 2^(32-code) bytes: code 1 gives 2 GB, code 2 gives 1 GB, and so on down to code 12, which gives 1 MB.
- R3: Size codes 13, 14 and 15 (0xD, 0xE, 0xF) select windows of 64 KB, 32 KB and 16 KB. `win_en` is 1 exactly when the size code is one of these three.
- R4: `cfg_rd_data` bits at or above log2(size) show the stored base. Bits below log2(size) read 0, and this includes the type and prefetch bits 3:0. A write on a clock edge shows on the read port after that edge.
- R5: A write stores only the bits at or above log2(size) for the size code in force at that edge. The lower data bits are dropped, so they still read 0 if the window is made smaller later.
- R6: A change of size code re-masks the stored base in the same cycle, for both the read port and the address compare. No clock edge is needed.
- R7: `hit` is 1 only when all of these hold: the register is on, `mem_space_en` is 1, and bus address bits at or above log2(size) equal the stored base bits.
- R8: If the masked base is zero, `hit` stays 0 while `allow_zero_base` is 0. While `allow_zero_base` is 1, a zero base decodes normally.
- R9: While the register is on, `offset` equals `bus_addr` AND (size-1).
- R10: An active-low reset clears the stored base to zero.
- R11: While `mem_space_en` is 0, `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Strobe that writes the register on this clock edge |
| cfg_wr_data | input | 32 | Data for a register write |
| cfg_rd_data | output | 32 | Register read value, masked to the current size |
| size_code | input | 4 | Window size code |
| allow_zero_base | input | 1 | Allows a base of zero to decode |
| mem_space_en | input | 1 | Memory-space enable bit of the command register |
| bus_addr | input | 32 | Bus address to decode |
| hit | output | 1 | The address falls in the window |
| offset | output | 32 | Offset of the address inside the window |
| win_en | output | 1 | A small window with internal translation is selected |

## Verification
Only one path has a delay: a register write shows on `cfg_rd_data`, and in the compare, one clock edge after its strobe. Every other result (`hit`, `offset`, `win_en`, and the re-masking after a size change) follows its inputs within the same cycle. The bench therefore sets the inputs just after a rising edge and compares all four outputs a short time later, before the next edge. Its model applies a pending write only after that edge has passed, so a write becomes visible exactly one cycle after its strobe, no sooner and no later.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;
    parameter int BAR_AW = 32;
    parameter int CODE_W = 4;
    // size codes 1..LARGE_CODES select 2^(BAR_AW-code) bytes
    parameter int LARGE_CODES = 12;
    // the first small code selects 2^SMALL_TOP_LG bytes, each next code halves it
    parameter int SMALL_TOP_LG = 16;

    typedef logic [BAR_AW-1:0] bar_word_t;
    typedef logic [CODE_W-1:0] size_code_t;
endpackage

// File: rtl/bar_size_decode.sv
module bar_size_decode
    import pci_bar_pkg::*;
#(
    parameter int AW = BAR_AW
) (
    input  size_code_t        code,
    output logic              enabled,
    output logic              small_win,
    output logic [AW-1:0]     keep_mask
);
    localparam int LG_W = $clog2(AW + 1);

    logic [LG_W-1:0] size_lg;

    always_comb begin
        int lg_i;
        enabled   = (code != '0);
        small_win = (int'(code) > LARGE_CODES);
        if (!small_win) lg_i = AW - int'(code);
        else            lg_i = SMALL_TOP_LG - (int'(code) - LARGE_CODES - 1);
        size_lg   = LG_W'(lg_i);
    end

    // one compare per bit: keep the bits at or above log2(size)
    for (genvar b = 0; b < AW; b++) begin : g_mask
        assign keep_mask[b] = enabled && (LG_W'(b) >= size_lg);
    end
endmodule

// File: rtl/bar_base_reg.sv
module bar_base_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic [AW-1:0] keep_mask,
    output logic [AW-1:0] base_live
);
    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     base_q <= '0;
        else if (wr_en) base_q <= wr_data & keep_mask;
    end

    // re-masked with the current size on every cycle
    assign base_live = base_q & keep_mask;
endmodule

// File: rtl/bar_addr_match.sv
module bar_addr_match #(
    parameter int AW = 32
) (
    input  logic          enabled,
    input  logic          mem_space_en,
    input  logic          allow_zero_base,
    input  logic [AW-1:0] keep_mask,
    input  logic [AW-1:0] base_live,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] offset
);
    logic upper_eq;
    logic base_ok;

    always_comb begin
        upper_eq = ((addr & keep_mask) == base_live);
        base_ok  = allow_zero_base || (base_live != '0);
        hit      = enabled && mem_space_en && upper_eq && base_ok;
        offset   = enabled ? (addr & ~keep_mask) : '0;
    end
endmodule

// File: rtl/pci_sized_bar.sv
module pci_sized_bar
    import pci_bar_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic [3:0]  size_code,
    input  logic        allow_zero_base,
    input  logic        mem_space_en,
    input  logic [31:0] bus_addr,
    output logic        hit,
    output logic [31:0] offset,
    output logic        win_en
);
    localparam int AW = BAR_AW;

    logic          enabled;
    logic [AW-1:0] keep_mask;
    logic [AW-1:0] base_live;

    bar_size_decode #(.AW(AW)) u_dec (
        .code      (size_code),
        .enabled   (enabled),
        .small_win (win_en),
        .keep_mask (keep_mask)
    );

    bar_base_reg #(.AW(AW)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .keep_mask (keep_mask),
        .base_live (base_live)
    );

    bar_addr_match #(.AW(AW)) u_match (
        .enabled         (enabled),
        .mem_space_en    (mem_space_en),
        .allow_zero_base (allow_zero_base),
        .keep_mask       (keep_mask),
        .base_live       (base_live),
        .addr            (bus_addr),
        .hit             (hit),
        .offset          (offset)
    );

    assign cfg_rd_data = base_live;
endmodule

// File: rtl/pci_sized_bar_chk.sv
module pci_sized_bar_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rd_data,
    input logic [3:0]  size_code,
    input logic        allow_zero_base,
    input logic        mem_space_en,
    input logic [31:0] bus_addr,
    input logic        hit,
    input logic [31:0] offset,
    input logic        win_en
);
    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == 4'h0) |-> (!hit && cfg_rd_data == 32'h0 && offset == 32'h0)); // R1
    AST_WIN_SMALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        win_en |-> (size_code >= 4'hD)); // R3
    AST_TYPE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data[3:0] == 4'h0)); // R4
    AST_ZERO_BASE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!allow_zero_base && cfg_rd_data == 32'h0) |-> !hit); // R8
    AST_HIT_SPLITS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((cfg_rd_data | offset) == bus_addr && (cfg_rd_data & offset) == 32'h0)); // R7
    AST_NO_MEM_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_space_en |-> !hit); // R11
endmodule

bind pci_sized_bar pci_sized_bar_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_rd_data     (cfg_rd_data),
    .size_code       (size_code),
    .allow_zero_base (allow_zero_base),
    .mem_space_en    (mem_space_en),
    .bus_addr        (bus_addr),
    .hit             (hit),
    .offset          (offset),
    .win_en          (win_en)
);

// File: tb/tb_pci_sized_bar.sv
`timescale 1ns/1ps
module tb_pci_sized_bar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic [3:0]  size_code = 4'h0;
    logic        allow_zero_base = 1'b0;
    logic        mem_space_en = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        hit;
    logic [31:0] offset;
    logic        win_en;

    int checks = 0;
    int failures = 0;
    logic [31:0] ref_base = '0;

    always #2.5 clk = ~clk;  // 200 MHz

    pci_sized_bar dut (.*);

    // mask of kept base bits, worked out from R1 to R3
    function automatic logic [31:0] ref_mask(input logic [3:0] c);
        int lg;
        longint unsigned sz;
        if (c == 0) return 32'h0;
        if (c <= 12) lg = 32 - int'(c);
        else         lg = 16 - (int'(c) - 13);
        sz = 64'd1 << lg;
        return ~(32'(sz - 1));
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [31:0] m;
        logic [31:0] e_rd, e_off;
        logic e_hit, e_win;
        m     = ref_mask(size_code);
        e_rd  = ref_base & m;
        e_hit = (size_code != 0) && mem_space_en && ((bus_addr & m) == e_rd)
                && (allow_zero_base || e_rd != 0);
        e_off = (size_code != 0) ? (bus_addr & ~m) : 32'h0;
        e_win = (size_code >= 4'hD);
        chk(tag, "rd_data", cfg_rd_data, e_rd);
        chk(tag, "hit", {31'h0, hit}, {31'h0, e_hit});
        chk(tag, "offset", offset, e_off);
        chk(tag, "win_en", {31'h0, win_en}, {31'h0, e_win});
    endtask

    // called just after a rising edge: drive, compare within the cycle, then cross the next edge
    task automatic step(input logic we, input logic [31:0] wd, input logic [3:0] code,
                        input logic azb, input logic mse, input logic [31:0] addr, input string tag);
        cfg_wr_en = we; cfg_wr_data = wd; size_code = code;
        allow_zero_base = azb; mem_space_en = mse; bus_addr = addr;
        #1;
        compare_all(tag);
        @(posedge clk);
        if (we && rst_n) ref_base = wd & ref_mask(code);
        #0.5;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: reset state
        @(posedge clk); #0.5;
        step(1'b1, 32'hFFFF_FFFF, 4'h1, 1'b0, 1'b1, 32'h0, "R10");
        rst_n = 1'b1;
        step(1'b0, 32'h0, 4'hC, 1'b1, 1'b1, 32'h0000_0100, "R10");

        // R2 and R3: all ones sizing on every code, then a hit inside the window
        for (int c = 1; c < 16; c++) begin
            string tg;
            tg = (c <= 12) ? "R2" : "R3";
            step(1'b1, 32'hFFFF_FFFF, 4'(c), 1'b0, 1'b1, 32'h0, tg);
            step(1'b0, 32'h0, 4'(c), 1'b0, 1'b1, 32'hFFFF_FFFF, tg);
            step(1'b0, 32'h0, 4'(c), 1'b0, 1'b1, 32'h0000_3FF0, tg);
        end

        // R1: off code hides everything
        step(1'b1, 32'h8000_0000, 4'h1, 1'b0, 1'b1, 32'h8000_1234, "R1");
        step(1'b0, 32'h0, 4'h0, 1'b0, 1'b1, 32'h8000_1234, "R1");
        step(1'b1, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b1, 32'h0, "R1");

        // R7 and R9: 256 MB window at 0x4000_0000
        step(1'b1, 32'h4000_0000, 4'h4, 1'b0, 1'b1, 32'h0, "R7");
        step(1'b0, 32'h0, 4'h4, 1'b0, 1'b1, 32'h4ABC_DEF0, "R9");
        step(1'b0, 32'h0, 4'h4, 1'b0, 1'b1, 32'h5000_0000, "R7");
        step(1'b0, 32'h0, 4'h4, 1'b0, 1'b1, 32'h3FFF_FFFF, "R7");

        // R11: memory space disabled
        step(1'b0, 32'h0, 4'h4, 1'b0, 1'b0, 32'h4000_0010, "R11");

        // R5: low bits dropped at the write, stay zero when the window shrinks
        step(1'b1, 32'hAAAA_AAAA, 4'h1, 1'b0, 1'b1, 32'h0, "R5");
        step(1'b0, 32'h0, 4'hF, 1'b0, 1'b1, 32'h8000_0000, "R5");
        // R6: shrink, write, then widen: readback and compare change in the same cycle
        step(1'b1, 32'h1234_5678, 4'hF, 1'b0, 1'b1, 32'h0, "R6");
        step(1'b0, 32'h0, 4'hF, 1'b0, 1'b1, 32'h1234_4000, "R6");
        step(1'b0, 32'h0, 4'h8, 1'b0, 1'b1, 32'h1200_0000, "R6");
        step(1'b0, 32'h0, 4'hC, 1'b0, 1'b1, 32'h1230_0001, "R6");

        // R8: zero base
        step(1'b1, 32'h000F_FFFF, 4'hC, 1'b0, 1'b1, 32'h0, "R8");
        step(1'b0, 32'h0, 4'hC, 1'b0, 1'b1, 32'h0001_2345, "R8");
        step(1'b0, 32'h0, 4'hC, 1'b1, 1'b1, 32'h0001_2345, "R8");
        step(1'b0, 32'h0, 4'hC, 1'b1, 1'b1, 32'h0010_0000, "R8");

        // R10: reset in the middle of a run
        step(1'b1, 32'hC000_0000, 4'h2, 1'b0, 1'b1, 32'h0, "R10");
        rst_n = 1'b0;
        ref_base = '0;
        step(1'b0, 32'h0, 4'h2, 1'b1, 1'b1, 32'h0, "R10");
        rst_n = 1'b1;
        step(1'b0, 32'h0, 4'h2, 1'b1, 1'b1, 32'hC000_0000, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule